// File: doc/BRIEF.md
# Vector length configuration execute unit

This unit is the execute stage of an instruction that configures vector length. It takes one decoded 32-bit instruction word, the value of its source register and the current 64-bit vector state register. From these it computes a new state register and a destination-register writeback. It also produces an optional 4-bit condition field. All outputs appear together, registered, one cycle after the request.

The instruction carries a 7-bit length immediate that holds the length minus one, so the lengths it can express run from 1 to 128. Two enable bits decide what happens. One loads the maximum vector length. The other sets the current vector length, either from the immediate or from the source register, and that length is clamped to the maximum. With both enables clear, the instruction only reads back the current length and changes no state. Whenever either enable is set, the vertical-first flag is rewritten and the persist flag is cleared.

Top module: `vls_unit`

## Requirements
- R1: `valid_o` is high for exactly the cycle after a cycle with `valid_i` high, and is 0 out of reset. `state_we_o`, `rt_we_o` and `cr_we_o` are 0 whenever `valid_o` is 0.
- R2: The length field is `insn_i[15:9]` and the effective length is that field plus one (1..128). When the set-maximum bit `insn_i[8]` is 1, the maximum field `state_o[63:57]` receives the effective length.
- R3: When the set-length bit `insn_i[7]` is 1 and the source index `insn_i[20:16]` is 0, the length field `state_o[56:50]` becomes min(effective length, effective maximum). The effective maximum is the new immediate when `insn_i[8]` is 1, and the old `state_i[63:57]` otherwise.
- R4: When `insn_i[7]` is 1 and the source index is nonzero, the length becomes min(`ra_val_i` taken as unsigned 64-bit, effective maximum).
- R5: When `insn_i[7]` is 0, the length field keeps its value from `state_i[56:50]`. When `insn_i[8]` is 0, the maximum field keeps its value from `state_i[63:57]`.
- R6: When `insn_i[8]` or `insn_i[7]` is 1, `state_we_o` is 1, `state_o[0]` takes the vertical-first request `insn_i[6]`, and `state_o[1]` (persist) is 0. All other state bits are copied from `state_i`.
- R7: When `insn_i[8]` and `insn_i[7]` are both 0, `state_we_o` is 0 and `state_o` equals `state_i`.
- R8: When the destination index `insn_i[25:21]` is nonzero, `rt_we_o` is 1, `rt_idx_o` carries the index, and `rt_val_o` is the 7-bit stored length zero-extended to 64 bits. When the index is 0, `rt_we_o` is 0.
- R9: When the record bit `insn_i[0]` is 1, `cr_we_o` is 1 and `cr_o` is {less-than, greater-than, equal, summary-overflow}, from a signed compare of `rt_val_o` with zero. Summary-overflow is always 0.
- R10: A computed length or maximum of 128 is stored as its low 7 bits, which is 0. The written-back length and the condition field follow the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Decoded instruction word |
| ra_val_i | input | 64 | Source register value |
| state_i | input | 64 | Current vector state register |
| valid_o | output | 1 | Result valid pulse |
| state_o | output | 64 | Next vector state register |
| state_we_o | output | 1 | State register write enable |
| rt_we_o | output | 1 | Destination write enable |
| rt_idx_o | output | 5 | Destination register index |
| rt_val_o | output | 64 | Destination write value |
| cr_we_o | output | 1 | Condition field write enable |
| cr_o | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
The hardest case to reach is a length of 128 wrapping to a stored 0. It needs the set-maximum and set-length bits together with the all-ones immediate, or a source value of at least 128 against a 128 maximum, and only then does the equal-to-zero condition appear. The sweep runs every immediate value under every enable and vertical-first combination. For each one it varies the source index, the destination index and the source values around the clamp point, and it plants zero maximum fields in the old state. A directed case then repeats the wrap on its own.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int XLEN_D   = 64;
  localparam int INSN_W_D = 32;
  localparam int LEN_W_D  = 7;
  localparam int IDX_W_D  = 5;
  localparam int CR_W     = 4;

  // field starts, MSB-first numbering
  localparam int IMM_FIRST = 16;
  localparam int MS_BIT    = 23;
  localparam int VS_BIT    = 24;
  localparam int VF_BIT    = 25;
  localparam int RT_FIRST  = 6;
  localparam int RA_FIRST  = 11;
  localparam int RC_BIT    = 31;

  localparam int MVL_FIRST = 0;
  localparam int VL_FIRST  = 7;
  localparam int PERS_POS  = 62;
  localparam int VFST_POS  = 63;

  typedef enum logic [1:0] {CR_SO = 2'd0, CR_EQ = 2'd1, CR_GT = 2'd2, CR_LT = 2'd3} cr_bit_e;
endpackage

// File: rtl/vls_decode.sv
module vls_decode import vls_pkg::*; #(
  parameter int INSN_W = INSN_W_D,
  parameter int LEN_W  = LEN_W_D,
  parameter int IDX_W  = IDX_W_D
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic [LEN_W-1:0]  imm_raw_o,
  output logic              ms_o,
  output logic              vs_o,
  output logic              vf_o,
  output logic              rc_o,
  output logic [IDX_W-1:0]  rt_o,
  output logic [IDX_W-1:0]  ra_o
);
  localparam int TOP = INSN_W - 1;

  genvar k;
  generate
    for (k = 0; k < LEN_W; k++) begin : g_imm
      assign imm_raw_o[LEN_W-1-k] = insn_i[TOP-(IMM_FIRST+k)];
    end
    for (k = 0; k < IDX_W; k++) begin : g_idx
      assign rt_o[IDX_W-1-k] = insn_i[TOP-(RT_FIRST+k)];
      assign ra_o[IDX_W-1-k] = insn_i[TOP-(RA_FIRST+k)];
    end
  endgenerate

  assign ms_o = insn_i[TOP-MS_BIT];
  assign vs_o = insn_i[TOP-VS_BIT];
  assign vf_o = insn_i[TOP-VF_BIT];
  assign rc_o = insn_i[TOP-RC_BIT];
endmodule

// File: rtl/vls_len.sv
module vls_len import vls_pkg::*; #(
  parameter int XLEN  = XLEN_D,
  parameter int LEN_W = LEN_W_D,
  parameter int IDX_W = IDX_W_D
) (
  input  logic [LEN_W-1:0] imm_raw_i,
  input  logic             ms_i,
  input  logic             vs_i,
  input  logic [IDX_W-1:0] ra_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [LEN_W-1:0] mvl_old_i,
  input  logic [LEN_W-1:0] vl_old_i,
  output logic [LEN_W-1:0] mvl_new_o,
  output logic [LEN_W-1:0] vl_new_o
);
  localparam int EFF_W = LEN_W + 1;

  logic [EFF_W-1:0] imm_eff;
  logic [EFF_W-1:0] mvl_eff;
  logic [XLEN-1:0]  src_len;
  logic [XLEN-1:0]  lim_len;
  logic [XLEN-1:0]  vl_full;

  assign imm_eff = {1'b0, imm_raw_i} + EFF_W'(1);
  assign mvl_eff = ms_i ? imm_eff : {1'b0, mvl_old_i};
  assign lim_len = {{(XLEN-EFF_W){1'b0}}, mvl_eff};
  assign src_len = (ra_i == '0) ? {{(XLEN-EFF_W){1'b0}}, imm_eff} : ra_val_i;
  assign vl_full = (src_len < lim_len) ? src_len : lim_len;

  // keep low bits: 128 folds to 0
  assign mvl_new_o = mvl_eff[LEN_W-1:0];
  assign vl_new_o  = vs_i ? vl_full[LEN_W-1:0] : vl_old_i;
endmodule

// File: rtl/vls_state.sv
module vls_state import vls_pkg::*; #(
  parameter int XLEN  = XLEN_D,
  parameter int LEN_W = LEN_W_D
) (
  input  logic [XLEN-1:0]  state_i,
  input  logic             ms_i,
  input  logic             vs_i,
  input  logic             vf_i,
  input  logic [LEN_W-1:0] mvl_new_i,
  input  logic [LEN_W-1:0] vl_new_i,
  output logic [LEN_W-1:0] mvl_old_o,
  output logic [LEN_W-1:0] vl_old_o,
  output logic [XLEN-1:0]  state_o,
  output logic             upd_o,
  output logic [XLEN-1:0]  rt_val_o,
  output logic [CR_W-1:0]  cr_o
);
  localparam int TOP = XLEN - 1;

  logic ovf;
  assign ovf = 1'b0;
  assign upd_o = ms_i | vs_i;

  genvar k;
  generate
    for (k = 0; k < LEN_W; k++) begin : g_fld
      assign mvl_old_o[LEN_W-1-k] = state_i[TOP-(MVL_FIRST+k)];
      assign vl_old_o[LEN_W-1-k]  = state_i[TOP-(VL_FIRST+k)];
    end
  endgenerate

  always_comb begin
    state_o = state_i;
    if (ms_i) begin
      for (int i = 0; i < LEN_W; i++) state_o[TOP-(MVL_FIRST+i)] = mvl_new_i[LEN_W-1-i];
    end
    for (int i = 0; i < LEN_W; i++) state_o[TOP-(VL_FIRST+i)] = vl_new_i[LEN_W-1-i];
    if (upd_o) begin
      state_o[TOP-VFST_POS] = vf_i;
      state_o[TOP-PERS_POS] = 1'b0;
    end
  end

  assign rt_val_o = {{(XLEN-LEN_W){1'b0}}, vl_new_i};

  always_comb begin
    cr_o        = '0;
    cr_o[CR_LT] = $signed(rt_val_o) < 0;
    cr_o[CR_GT] = $signed(rt_val_o) > 0;
    cr_o[CR_EQ] = rt_val_o == '0;
    cr_o[CR_SO] = ovf;
  end
endmodule

// File: rtl/vls_unit.sv
module vls_unit import vls_pkg::*; #(
  parameter int XLEN   = XLEN_D,
  parameter int INSN_W = INSN_W_D,
  parameter int LEN_W  = LEN_W_D,
  parameter int IDX_W  = IDX_W_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   state_i,
  output logic              valid_o,
  output logic [XLEN-1:0]   state_o,
  output logic              state_we_o,
  output logic              rt_we_o,
  output logic [IDX_W-1:0]  rt_idx_o,
  output logic [XLEN-1:0]   rt_val_o,
  output logic              cr_we_o,
  output logic [CR_W-1:0]   cr_o
);
  logic [LEN_W-1:0] imm_raw, mvl_old, vl_old, mvl_new, vl_new;
  logic             ms, vs, vf, rc, upd;
  logic [IDX_W-1:0] rt, ra;
  logic [XLEN-1:0]  state_nxt, rt_val_nxt;
  logic [CR_W-1:0]  cr_nxt;

  vls_decode #(.INSN_W(INSN_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_dec (
    .insn_i(insn_i), .imm_raw_o(imm_raw), .ms_o(ms), .vs_o(vs), .vf_o(vf),
    .rc_o(rc), .rt_o(rt), .ra_o(ra)
  );

  vls_len #(.XLEN(XLEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_len (
    .imm_raw_i(imm_raw), .ms_i(ms), .vs_i(vs), .ra_i(ra), .ra_val_i(ra_val_i),
    .mvl_old_i(mvl_old), .vl_old_i(vl_old), .mvl_new_o(mvl_new), .vl_new_o(vl_new)
  );

  vls_state #(.XLEN(XLEN), .LEN_W(LEN_W)) u_st (
    .state_i(state_i), .ms_i(ms), .vs_i(vs), .vf_i(vf), .mvl_new_i(mvl_new),
    .vl_new_i(vl_new), .mvl_old_o(mvl_old), .vl_old_o(vl_old), .state_o(state_nxt),
    .upd_o(upd), .rt_val_o(rt_val_nxt), .cr_o(cr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      state_we_o <= 1'b0;
      rt_we_o    <= 1'b0;
      cr_we_o    <= 1'b0;
      state_o    <= '0;
      rt_idx_o   <= '0;
      rt_val_o   <= '0;
      cr_o       <= '0;
    end else begin
      valid_o    <= valid_i;
      state_we_o <= valid_i & upd;
      rt_we_o    <= valid_i & (rt != '0);
      cr_we_o    <= valid_i & rc;
      if (valid_i) begin
        state_o  <= state_nxt;
        rt_idx_o <= rt;
        rt_val_o <= rt_val_nxt;
        cr_o     <= cr_nxt;
      end
    end
  end
endmodule

// File: rtl/vls_unit_chk.sv
module vls_unit_chk import vls_pkg::*; #(
  parameter int XLEN   = XLEN_D,
  parameter int INSN_W = INSN_W_D,
  parameter int LEN_W  = LEN_W_D,
  parameter int IDX_W  = IDX_W_D
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [INSN_W-1:0] insn_i,
  input logic [XLEN-1:0]   ra_val_i,
  input logic [XLEN-1:0]   state_i,
  input logic              valid_o,
  input logic [XLEN-1:0]   state_o,
  input logic              state_we_o,
  input logic              rt_we_o,
  input logic [IDX_W-1:0]  rt_idx_o,
  input logic [XLEN-1:0]   rt_val_o,
  input logic              cr_we_o,
  input logic [CR_W-1:0]   cr_o
);
  assert_valid_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_we_gated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(state_we_o | rt_we_o | cr_we_o));
  assert_persist_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_we_o |-> !state_o[XLEN-1-PERS_POS]);
  assert_state_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !state_we_o) |-> state_o == $past(state_i));
  assert_rt_zext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_we_o |-> rt_val_o[XLEN-1:LEN_W] == '0);
  assert_cr_form_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (!cr_o[CR_SO] && !cr_o[CR_LT] && $countones(cr_o) == 1
                 && cr_o[CR_EQ] == (rt_val_o == '0)));
endmodule

bind vls_unit vls_unit_chk #(.XLEN(XLEN), .INSN_W(INSN_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_vls_unit.sv
`timescale 1ns/1ps
module sim_vls_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] ra_val_i = '0;
  logic [63:0] state_i = '0;
  logic        valid_o, state_we_o, rt_we_o, cr_we_o;
  logic [63:0] state_o, rt_val_o;
  logic [4:0]  rt_idx_o;
  logic [3:0]  cr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  vls_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] ra, input logic [6:0] imm,
                                     input bit ms, input bit vs, input bit vf, input bit rc);
    logic [31:0] w = '0;
    w[25:21] = rt; w[20:16] = ra; w[15:9] = imm;
    w[8] = ms; w[7] = vs; w[6] = vf; w[0] = rc;
    return w;
  endfunction

  task automatic run_op(input logic [31:0] w, input logic [63:0] rav, input logic [63:0] st, input string tag_extra);
    logic [7:0]  imm8, mvl8;
    logic [63:0] src, lim, vlf, exp_st, exp_rt;
    logic [6:0]  vl7;
    logic [3:0]  exp_cr;
    bit ms, vs, vf;
    string stag;
    ms = w[8]; vs = w[7]; vf = w[6];
    imm8 = {1'b0, w[15:9]} + 8'd1;
    mvl8 = ms ? imm8 : {1'b0, st[63:57]};
    src  = (w[20:16] == 0) ? {56'd0, imm8} : rav;
    lim  = {56'd0, mvl8};
    vlf  = (src < lim) ? src : lim;
    vl7  = vs ? vlf[6:0] : st[56:50];
    exp_st = st;
    if (ms) exp_st[63:57] = mvl8[6:0];
    exp_st[56:50] = vl7;
    if (ms | vs) begin exp_st[0] = vf; exp_st[1] = 1'b0; end
    exp_rt = {57'd0, vl7};
    exp_cr = (vl7 == 0) ? 4'b0010 : 4'b0100;
    if (vs && w[20:16] == 0) stag = "R3";
    else if (vs) stag = "R4";
    else if (ms) stag = "R2";
    else stag = "R7";

    insn_i = w; ra_val_i = rav; state_i = st; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o == 1'b1, "R1 valid pulse", {63'd0, valid_o}, 64'd1);
    chk(state_o == exp_st, {stag, " state", tag_extra}, state_o, exp_st);
    if (!vs) chk(state_o[56:50] == st[56:50], "R5 length kept", {57'd0, state_o[56:50]}, {57'd0, st[56:50]});
    if (!ms) chk(state_o[63:57] == st[63:57], "R5 max kept", {57'd0, state_o[63:57]}, {57'd0, st[63:57]});
    chk(state_we_o == (ms | vs), (ms | vs) ? "R6 state we" : "R7 state we", {63'd0, state_we_o}, {63'd0, ms | vs});
    if (ms | vs) chk(state_o[1:0] == {1'b0, vf}, "R6 flags", {62'd0, state_o[1:0]}, {62'd0, 1'b0, vf});
    chk(rt_we_o == (w[25:21] != 0), "R8 rt we", {63'd0, rt_we_o}, {63'd0, w[25:21] != 0});
    if (w[25:21] != 0) begin
      chk(rt_idx_o == w[25:21], "R8 rt idx", {59'd0, rt_idx_o}, {59'd0, w[25:21]});
      chk(rt_val_o == exp_rt, "R8 rt val", rt_val_o, exp_rt);
    end
    chk(cr_we_o == w[0], "R9 cr we", {63'd0, cr_we_o}, {63'd0, w[0]});
    if (w[0]) chk(cr_o == exp_cr, "R9 cr", {60'd0, cr_o}, {60'd0, exp_cr});
    @(negedge clk_i);
    chk(!valid_o && !state_we_o && !rt_we_o && !cr_we_o, "R1 idle",
        {60'd0, valid_o, state_we_o, rt_we_o, cr_we_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!valid_o && !state_we_o && !rt_we_o && !cr_we_o && state_o == 0, "R1 reset",
        {60'd0, valid_o, state_we_o, rt_we_o, cr_we_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int imm = 0; imm < 128; imm++) begin
      for (int mode = 0; mode < 8; mode++) begin
        for (int v = 0; v < 4; v++) begin
          logic [63:0] st, rav;
          logic [4:0]  rt, ra;
          st = {$random, $random};
          if (imm % 8 == 0) st[63:57] = 7'd0;
          if (imm % 8 == 1) st[63:57] = 7'd127;
          case (imm % 4)
            0: rav = 64'(imm);
            1: rav = 64'(imm * 2);
            2: rav = 64'hFFFF_FFFF_FFFF_FFF0;
            default: rav = 64'd200;
          endcase
          ra = v[1] ? 5'd3 : 5'd0;
          rt = v[0] ? 5'((imm % 31) + 1) : 5'd0;
          run_op(mk(rt, ra, 7'(imm), mode[2], mode[1], mode[0], v[0] ^ mode[0]), rav, st, "");
        end
      end
    end

    // R10: all-ones immediate with both enables gives 128, stored as 0
    run_op(mk(5'd9, 5'd0, 7'h7F, 1'b1, 1'b1, 1'b1, 1'b1), 64'd0, 64'h0123_4567_89AB_CDEF, " R10");
    chk(state_o[63:50] == 14'd0 && rt_val_o == 64'd0 && cr_o == 4'b0010, "R10 wrap",
        {50'd0, state_o[63:50]}, 64'd0);
    // R10: source value above 128 against a 128 maximum
    run_op(mk(5'd4, 5'd2, 7'h7F, 1'b1, 1'b1, 1'b0, 1'b1), 64'd1000, 64'd0, " R10");
    chk(rt_val_o == 64'd0, "R10 wrap from source", rt_val_o, 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule